// File: doc/BRIEF.md
# Floating-Point Status and Exception Register

This block keeps the control and status word of a floating-point unit. After each arithmetic operation, the execution pipe hands it the raw IEEE exception flags of that operation, together with a per-operation mask of flags to hide. The block converts the surviving flags into its own bit order and always replaces the cause field with them. It then makes one of two updates. If any surviving exception is enabled, it raises a one-cycle trap request and leaves the sticky flags as they were. Otherwise it ORs the surviving flags into the sticky field.

The same word holds a two-bit rounding-mode field. The block decodes this field into a registered one-hot selection that the arithmetic units use. Flush-to-zero is reported as permanently off. Software loads the whole word through a single-cycle write port. When a write and an operation arrive in the same cycle, the write wins.

Top module: `fpcsr_unit`

## Requirements
- R1: After reset, `csr_o` is zero, `trap_req` is low and `rnd_sel` is 4'b0001.
- R2: The word layout is as follows: enables at [4:0], rounding mode at [9:8], sticky flags at [20:16] and cause at [28:24]. In every 5-bit group, bit 4 is invalid, bit 3 is divide-by-zero, bit 2 is overflow, bit 1 is underflow and bit 0 is inexact. A write stores `wr_data` into these fields, and every other bit reads as zero.
- R3: `op_flags` and `op_mask` use the raw order: bit 0 invalid, bit 1 divide-by-zero, bit 2 overflow, bit 3 underflow, bit 4 inexact. A flag whose mask bit is set is discarded before any other evaluation.
- R4: If no flag survives the mask, the cause field becomes zero, no trap is raised, and all other fields keep their values.
- R5: If flags survive, the cause field holds exactly the surviving flags, in the register order. Earlier cause bits are not kept.
- R6: If any surviving flag has its enable bit set, `trap_req` is high for the single cycle after the update, and the sticky flags keep their previous value.
- R7: If surviving flags exist and none of them is enabled, they are ORed into the sticky flag field and `trap_req` stays low.
- R8: `rnd_sel` is one-hot and changes in the same cycle as the rounding field. Field value 0 selects bit 0 (nearest-even), 1 selects bit 1 (toward zero), 2 selects bit 2 (toward +infinity) and 3 selects bit 3 (toward -infinity).
- R9: A write in the same cycle as an operation takes priority. The operation is dropped and no trap is raised.
- R10: `ftz_en` is always low.
- R11: When neither `wr_en` nor `op_valid` is high, the register is unchanged and `trap_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Value to load into the word |
| op_valid | input | 1 | One operation completed this cycle |
| op_flags | input | 5 | Raw IEEE exception flags of the operation |
| op_mask | input | 5 | Flags to hide for this operation |
| csr_o | output | 32 | Current control and status word |
| trap_req | output | 1 | Floating-point exception request pulse |
| rnd_sel | output | 4 | One-hot rounding selection |
| ftz_en | output | 1 | Flush-to-zero enable, always zero |

## Verification
The assertions assume three things about the inputs:
- Reset is held from time zero.
- All inputs are known at every clock edge.
- `op_flags` and `op_mask` carry meaning only while `op_valid` is high.

The past-value checks are gated on the cycle before not being a reset cycle, so they never look at values from before reset. The bench drives every input on the falling edge and keeps all inputs at zero during reset. It returns the strobes to zero after each scenario step, so each operation or write is seen at exactly one rising edge.

// File: rtl/fpcsr_pkg.sv
`timescale 1ns/1ps
package fpcsr_pkg;
  // Default geometry of the control/status word
  localparam int CSR_W_D   = 32;
  localparam int EXC_N_D   = 5;
  localparam int RM_W_D    = 2;
  localparam int EN_LSB_D  = 0;
  localparam int RM_LSB_D  = 8;
  localparam int FLG_LSB_D = 16;
  localparam int CAU_LSB_D = 24;

  // Rounding-mode field encoding
  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'd0,
    RND_TO_ZERO   = 2'd1,
    RND_TO_PINF   = 2'd2,
    RND_TO_NINF   = 2'd3
  } rnd_mode_e;
endpackage

// File: rtl/fpcsr_flag_map.sv
`timescale 1ns/1ps
// Reorders raw exception flags (invalid at bit 0) into register order
// (invalid at the top bit).
module fpcsr_flag_map #(
  parameter int N = 5
) (
  input  logic [N-1:0] raw,
  output logic [N-1:0] mapped
);
  for (genvar i = 0; i < N; i++) begin : g_map
    assign mapped[N-1-i] = raw[i];
  end
endmodule

// File: rtl/fpcsr_exc_eval.sv
`timescale 1ns/1ps
// Applies the per-operation suppression mask and decides whether to trap.
module fpcsr_exc_eval #(
  parameter int N = 5
) (
  input  logic [N-1:0] raw_flags,
  input  logic [N-1:0] raw_mask,
  input  logic [N-1:0] enables,
  output logic [N-1:0] surv,
  output logic         any_surv,
  output logic         trap_hit
);
  logic [N-1:0] kept_raw;

  assign kept_raw = raw_flags & ~raw_mask;

  fpcsr_flag_map #(.N(N)) u_map (
    .raw    (kept_raw),
    .mapped (surv)
  );

  assign any_surv = |surv;
  assign trap_hit = |(surv & enables);
endmodule

// File: rtl/fpcsr_rnd_dec.sv
`timescale 1ns/1ps
// Decodes the rounding field into a one-hot selection.
module fpcsr_rnd_dec #(
  parameter int RM_W = 2
) (
  input  logic [RM_W-1:0]        rm,
  output logic [(1<<RM_W)-1:0]   sel
);
  for (genvar i = 0; i < (1 << RM_W); i++) begin : g_sel
    assign sel[i] = (rm == RM_W'(i));
  end
endmodule

// File: rtl/fpcsr_unit.sv
`timescale 1ns/1ps
module fpcsr_unit
  import fpcsr_pkg::*;
#(
  parameter int CSR_W   = CSR_W_D,
  parameter int EXC_N   = EXC_N_D,
  parameter int RM_W    = RM_W_D,
  parameter int EN_LSB  = EN_LSB_D,
  parameter int RM_LSB  = RM_LSB_D,
  parameter int FLG_LSB = FLG_LSB_D,
  parameter int CAU_LSB = CAU_LSB_D
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [CSR_W-1:0]       wr_data,
  input  logic                   op_valid,
  input  logic [EXC_N-1:0]       op_flags,
  input  logic [EXC_N-1:0]       op_mask,
  output logic [CSR_W-1:0]       csr_o,
  output logic                   trap_req,
  output logic [(1<<RM_W)-1:0]   rnd_sel,
  output logic                   ftz_en
);
  localparam int MODES = 1 << RM_W;
  localparam logic [CSR_W-1:0] EXC_ONES = CSR_W'((1 << EXC_N) - 1);
  localparam logic [CSR_W-1:0] RM_ONES  = CSR_W'((1 << RM_W) - 1);
  localparam logic [CSR_W-1:0] KEEP_MASK =
      (EXC_ONES << EN_LSB) | (RM_ONES << RM_LSB) |
      (EXC_ONES << FLG_LSB) | (EXC_ONES << CAU_LSB);

  // Field registers
  logic [EXC_N-1:0] en_q,  en_d;
  logic [RM_W-1:0]  rm_q,  rm_d;
  logic [EXC_N-1:0] flg_q, flg_d;
  logic [EXC_N-1:0] cau_q, cau_d;
  logic             trap_q, trap_d;
  logic [MODES-1:0] sel_q, sel_d;

  logic [EXC_N-1:0] surv;
  logic             any_surv;
  logic             trap_hit;
  logic             unused_wr_bits;

  assign unused_wr_bits = ^(wr_data & ~KEEP_MASK);

  fpcsr_exc_eval #(.N(EXC_N)) u_eval (
    .raw_flags (op_flags),
    .raw_mask  (op_mask),
    .enables   (en_q),
    .surv      (surv),
    .any_surv  (any_surv),
    .trap_hit  (trap_hit)
  );

  // Next-state selection: write beats operation update
  always_comb begin
    en_d   = en_q;
    rm_d   = rm_q;
    flg_d  = flg_q;
    cau_d  = cau_q;
    trap_d = 1'b0;
    if (wr_en) begin
      en_d  = wr_data[EN_LSB  +: EXC_N];
      rm_d  = wr_data[RM_LSB  +: RM_W];
      flg_d = wr_data[FLG_LSB +: EXC_N];
      cau_d = wr_data[CAU_LSB +: EXC_N];
    end else if (op_valid) begin
      cau_d = surv;
      if (any_surv) begin
        if (trap_hit) begin
          trap_d = 1'b1;
        end else begin
          flg_d = flg_q | surv;
        end
      end
    end
  end

  fpcsr_rnd_dec #(.RM_W(RM_W)) u_rdec (
    .rm  (rm_d),
    .sel (sel_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      rm_q   <= '0;
      flg_q  <= '0;
      cau_q  <= '0;
      trap_q <= 1'b0;
      sel_q  <= MODES'(1);
    end else begin
      en_q   <= en_d;
      rm_q   <= rm_d;
      flg_q  <= flg_d;
      cau_q  <= cau_d;
      trap_q <= trap_d;
      sel_q  <= sel_d;
    end
  end

  always_comb begin
    csr_o = '0;
    csr_o[EN_LSB  +: EXC_N] = en_q;
    csr_o[RM_LSB  +: RM_W]  = rm_q;
    csr_o[FLG_LSB +: EXC_N] = flg_q;
    csr_o[CAU_LSB +: EXC_N] = cau_q;
  end

  assign trap_req = trap_q;
  assign rnd_sel  = sel_q;
  assign ftz_en   = 1'b0;
endmodule

// File: rtl/fpcsr_unit_chk.sv
`timescale 1ns/1ps
module fpcsr_unit_chk #(
  parameter int CSR_W   = 32,
  parameter int EXC_N   = 5,
  parameter int RM_W    = 2,
  parameter int EN_LSB  = 0,
  parameter int RM_LSB  = 8,
  parameter int FLG_LSB = 16,
  parameter int CAU_LSB = 24
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [CSR_W-1:0]     wr_data,
  input logic                 op_valid,
  input logic [EXC_N-1:0]     op_flags,
  input logic [EXC_N-1:0]     op_mask,
  input logic [CSR_W-1:0]     csr_o,
  input logic                 trap_req,
  input logic [(1<<RM_W)-1:0] rnd_sel,
  input logic                 ftz_en
);
  localparam logic [CSR_W-1:0] ONES5 = CSR_W'((1 << EXC_N) - 1);
  localparam logic [CSR_W-1:0] ONES2 = CSR_W'((1 << RM_W) - 1);
  localparam logic [CSR_W-1:0] KEEP =
      (ONES5 << EN_LSB) | (ONES2 << RM_LSB) | (ONES5 << FLG_LSB) | (ONES5 << CAU_LSB);

  logic [EXC_N-1:0] c_flg, c_cau, c_en;
  logic [RM_W-1:0]  c_rm;
  logic             unused_ftz;
  assign c_flg = csr_o[FLG_LSB +: EXC_N];
  assign c_cau = csr_o[CAU_LSB +: EXC_N];
  assign c_en  = csr_o[EN_LSB  +: EXC_N];
  assign c_rm  = csr_o[RM_LSB  +: RM_W];
  assign unused_ftz = ftz_en;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (csr_o & ~KEEP) == '0); // R2

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && wr_en) |-> (csr_o == ($past(wr_data) & KEEP)) && !trap_req); // R9

  AST_TRAP_HOLDS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (trap_req && $past(!rst)) |-> (c_flg == $past(c_flg)) && ((c_cau & c_en) != '0)); // R6

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !wr_en && !op_valid) |-> (csr_o == $past(csr_o)) && !trap_req); // R11

  AST_RND_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    ($countones(rnd_sel) == 1) && rnd_sel[c_rm]); // R8

  AST_STICKY_GROW: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !wr_en) |-> ((c_flg & $past(c_flg)) == $past(c_flg))); // R7

  AST_NO_SURVIVOR: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !wr_en && op_valid && ((op_flags & ~op_mask) == '0))
      |-> (c_cau == '0) && !trap_req && (c_flg == $past(c_flg)) && (c_en == $past(c_en))); // R4
endmodule

bind fpcsr_unit fpcsr_unit_chk #(
  .CSR_W(CSR_W), .EXC_N(EXC_N), .RM_W(RM_W), .EN_LSB(EN_LSB),
  .RM_LSB(RM_LSB), .FLG_LSB(FLG_LSB), .CAU_LSB(CAU_LSB)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .op_valid(op_valid),
  .op_flags(op_flags), .op_mask(op_mask), .csr_o(csr_o), .trap_req(trap_req),
  .rnd_sel(rnd_sel), .ftz_en(ftz_en)
);

// File: tb/fpcsr_unit_bench.sv
`timescale 1ns/1ps
module fpcsr_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        op_valid = 1'b0;
  logic [4:0]  op_flags = '0;
  logic [4:0]  op_mask = '0;
  logic [31:0] csr_o;
  logic        trap_req;
  logic [3:0]  rnd_sel;
  logic        ftz_en;

  int checks = 0;
  int fails  = 0;

  // Reference model state
  logic [4:0] m_en, m_flg, m_cau;
  logic [1:0] m_rm;
  logic       m_trap;

  always #2.5 clk = ~clk;

  fpcsr_unit u_fpcsr_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .op_valid(op_valid),
    .op_flags(op_flags), .op_mask(op_mask), .csr_o(csr_o), .trap_req(trap_req),
    .rnd_sel(rnd_sel), .ftz_en(ftz_en)
  );

  function automatic logic [31:0] exp_csr();
    return {3'b0, m_cau, 3'b0, m_flg, 6'b0, m_rm, 3'b0, m_en};
  endfunction

  // Raw order (invalid at bit 0) to register order (invalid at bit 4)
  function automatic logic [4:0] to_reg(input logic [4:0] raw);
    logic [4:0] r;
    for (int i = 0; i < 5; i++) r[4-i] = raw[i];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " csr"},  csr_o, exp_csr());
    check({req, " trap"}, {31'b0, trap_req}, {31'b0, m_trap});
    check({req, " rnd"},  {28'b0, rnd_sel}, 32'(4'b0001 << m_rm));
  endtask

  // One clock of stimulus; model updated from the requirements
  task automatic step(input logic we, input logic [31:0] wd, input logic ov,
                      input logic [4:0] fl, input logic [4:0] mk);
    logic [4:0] s;
    @(negedge clk);
    wr_en = we; wr_data = wd; op_valid = ov; op_flags = fl; op_mask = mk;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; op_valid = 1'b0; op_flags = '0; op_mask = '0;
    m_trap = 1'b0;
    if (we) begin
      m_en = wd[4:0]; m_rm = wd[9:8]; m_flg = wd[20:16]; m_cau = wd[28:24];
    end else if (ov) begin
      s = to_reg(fl & ~mk);
      m_cau = s;
      if ((s & m_en) != 0) m_trap = 1'b1;
      else m_flg = m_flg | s;
    end
  endtask

  task automatic t_reset();
    m_en = '0; m_rm = '0; m_flg = '0; m_cau = '0; m_trap = 1'b0;
    check_all("R1 reset");
    check("R10 ftz", {31'b0, ftz_en}, 32'd0);
  endtask

  task automatic t_write();
    step(1'b1, 32'hFFFF_FFFF, 1'b0, 5'd0, 5'd0);
    check("R2 write all ones", csr_o, 32'h1F1F_031F);
    check_all("R2 write");
    for (int m = 0; m < 4; m++) begin
      step(1'b1, 32'(m) << 8, 1'b0, 5'd0, 5'd0);
      check("R8 rnd decode", {28'b0, rnd_sel}, 32'(4'b0001 << m));
    end
  endtask

  task automatic t_mask();
    step(1'b1, 32'h0000_0000, 1'b0, 5'd0, 5'd0);
    step(1'b0, 32'd0, 1'b1, 5'h1F, 5'h1F);
    check_all("R4 all masked");
    // raw bit1 = div0 -> register bit3
    step(1'b0, 32'd0, 1'b1, 5'b00010, 5'd0);
    check("R3 div0 mapping", csr_o, 32'h0808_0000);
    check_all("R3 map");
  endtask

  task automatic t_cause();
    // raw bit4 = inexact -> register bit0; earlier div0 cause discarded
    step(1'b0, 32'd0, 1'b1, 5'b10000, 5'd0);
    check("R5 cause overwrite", csr_o, 32'h0109_0000);
    step(1'b1, 32'd0, 1'b0, 5'd0, 5'd0);
    step(1'b0, 32'd0, 1'b1, 5'h1F, 5'd0);
    check("R7 accumulate all", csr_o, 32'h1F1F_0000);
    check_all("R7");
  endtask

  task automatic t_trap();
    // enable overflow only, sticky inexact preset
    step(1'b1, 32'h0001_0004, 1'b0, 5'd0, 5'd0);
    step(1'b0, 32'd0, 1'b1, 5'b10100, 5'd0);
    check("R6 trap raised", {31'b0, trap_req}, 32'd1);
    check("R6 sticky kept", csr_o, 32'h0501_0004);
    step(1'b0, 32'd0, 1'b0, 5'd0, 5'd0);
    check("R6 pulse ends", {31'b0, trap_req}, 32'd0);
    check_all("R11 idle");
    // overflow masked, inexact survives: no trap
    step(1'b0, 32'd0, 1'b1, 5'b10100, 5'b00100);
    check("R3 masked enable", {31'b0, trap_req}, 32'd0);
    check_all("R3 masked");
  endtask

  task automatic t_priority();
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'hE0E0_02E4; op_valid = 1'b1; op_flags = 5'b00100; op_mask = '0;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; op_valid = 1'b0; op_flags = '0;
    m_en = 5'h04; m_rm = 2'd2; m_flg = '0; m_cau = '0; m_trap = 1'b0;
    check("R9 write wins", csr_o, 32'h0000_0204);
    check_all("R9");
    check("R10 ftz", {31'b0, ftz_en}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write();
    t_mask();
    t_cause();
    t_trap();
    t_priority();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule